// File: doc/BRIEF.md
# Pick-and-Place Arm Step Sequencer

This block is a synchronous sequencer for a two-axis arm that carries one workpiece from a rear pick-up point to a front drop-off point. It reads four position switches (rear, front, bottom, top), two gripper switches (open, closed) and a start request. It drives five actuator commands: back, forward, down, up and grip. Each motion command stays asserted until the switch that marks the end of that motion is seen. Only then does the sequencer move to the next step.

The arm parks at front-top. One start request runs one full cycle:
- move back, then lower, at the rear;
- grip the part, then lift;
- move forward, then lower, at the front;
- release the part, lift, and return to park.

A part in the gripper shows as both gripper switches low. If the closed switch rises while a part should be held, the part was lost (or never caught). The sequencer then latches a fault and skips placement. It lifts the arm and moves it forward to park, and it refuses new starts until a clear is given at park. A hard interlock removes horizontal commands whenever the bottom switch reads active.

All switch inputs pass through a parameterised synchronizer (`SYNC_STAGES`, 0 to 4) before they reach the sequencing logic.

Top module: `arm_seq`

## Requirements
- R1: After reset, step_o is 0 (park), all five commands are low, and fault_o and held_o are low.
- R2: With no fault, a start request at park produces step codes in this order: 1 (back), 2 (lower at rear), 3 (grip), 4 (lift), 5 (forward), 6 (lower at front), 7 (release), 8 (lift at front), 0 (park). A step ends only when its target is seen: rear, bottom, part held (open=0 and closed=0), top, front, bottom, released (open=1 and closed=0), and top. Until then the step code and its command do not change.
- R3: Commands per step, written as {back,fwd,down,up,grip}, are: 1=10000, 2=00100, 3=00001, 4=00011, 5=01001, 6=00101, 8=00010, 9=00010, 10=01000, and 0 and 7=00000.
- R4: At most one of cmd_back, cmd_fwd, cmd_down and cmd_up is high in any cycle.
- R5: While sens_bottom is high, cmd_fwd and cmd_back are low in the same cycle.
- R6: If grip_closed reads 1 during step 4, 5 or 6, fault_o is set, held_o drops, and the steps go 9 (abort lift), then 10 (abort forward), then 0. Step 6 or 7 is not entered, and the arm never reaches front-bottom while the fault is latched.
- R7: If grip_closed reads 1 during step 3 (the grip closed on nothing), the same abort path as R6 is taken and the fault is latched.
- R8: held_o is high from the end of grip until release completes, and held_o and fault_o are never high together.
- R9: The fault stays set until fault_clr is seen at step 0. A fault_clr at any other step is ignored. A start request at park is ignored while the fault is set.
- R10: At step 0 with no start request, the step code stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one pick-and-place cycle |
| fault_clr | input | 1 | Clear the latched fault (accepted only at park) |
| sens_rear | input | 1 | Arm at rear limit |
| sens_front | input | 1 | Arm at front limit |
| sens_bottom | input | 1 | Arm at lower limit |
| sens_top | input | 1 | Arm at upper limit |
| grip_open | input | 1 | Gripper fully open |
| grip_closed | input | 1 | Gripper closed with nothing between the jaws |
| cmd_back | output | 1 | Drive arm toward rear |
| cmd_fwd | output | 1 | Drive arm toward front |
| cmd_down | output | 1 | Lower the arm |
| cmd_up | output | 1 | Raise the arm |
| cmd_grip | output | 1 | Close the gripper (low opens it) |
| step_o | output | 4 | Current step code |
| held_o | output | 1 | A part is believed held |
| fault_o | output | 1 | Latched lost-part fault |

## Verification
The hardest situation to reach is a part lost at a precise point in transport. The closed switch has to rise while the arm is still moving, and late enough that the part was really gripped. The bench contains a small plant model that moves the arm one position unit per cycle and closes the gripper after a delay. A drop request makes the plant release the held part at the moment the sequencer enters the lift, forward or lower-at-front step. A part-absent flag makes the grip close on nothing. The vertical travel is long enough that the abort lands before the arm reaches front-bottom. A freeze flag stalls the plant in mid-travel to show that the step waits for its switch.

// File: rtl/arm_seq_pkg.sv
package arm_seq_pkg;

   localparam int ARM_STEP_W = 4;
   localparam int ARM_SENSE_W = 6;

   typedef enum logic [ARM_STEP_W-1:0] {
      ST_PARK      = 4'd0,
      ST_BACK      = 4'd1,
      ST_LOWER_R   = 4'd2,
      ST_GRIP      = 4'd3,
      ST_LIFT_R    = 4'd4,
      ST_FWD       = 4'd5,
      ST_LOWER_F   = 4'd6,
      ST_RELEASE   = 4'd7,
      ST_LIFT_F    = 4'd8,
      ST_ABORT_UP  = 4'd9,
      ST_ABORT_FWD = 4'd10
   } arm_step_e;

   typedef struct packed {
      logic back;
      logic fwd;
      logic down;
      logic up;
      logic grip;
   } arm_cmd_t;

   typedef struct packed {
      logic rear;
      logic front;
      logic bottom;
      logic top;
      logic open;
      logic closed;
   } arm_sense_t;

   function automatic arm_cmd_t step_to_cmd(input arm_step_e s);
      arm_cmd_t c;
      c = '0;
      unique case (s)
         ST_BACK:      c.back = 1'b1;
         ST_LOWER_R:   c.down = 1'b1;
         ST_GRIP:      c.grip = 1'b1;
         ST_LIFT_R:    begin c.up = 1'b1;   c.grip = 1'b1; end
         ST_FWD:       begin c.fwd = 1'b1;  c.grip = 1'b1; end
         ST_LOWER_F:   begin c.down = 1'b1; c.grip = 1'b1; end
         ST_LIFT_F:    c.up = 1'b1;
         ST_ABORT_UP:  c.up = 1'b1;
         ST_ABORT_FWD: c.fwd = 1'b1;
         default:      c = '0;
      endcase
      return c;
   endfunction

   function automatic logic step_carries(input arm_step_e s);
      return (s == ST_GRIP) || (s == ST_LIFT_R) || (s == ST_FWD) || (s == ST_LOWER_F);
   endfunction

endpackage

// File: rtl/arm_seq_sync.sv
module arm_seq_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  pipe[i] <= pipe[i-1];
               end
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/arm_seq_fsm.sv
module arm_seq_fsm
   import arm_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_req,
   input  logic       fault_clr,
   input  arm_sense_t sense,
   output arm_step_e  step,
   output logic       held,
   output logic       fault
);

   arm_step_e step_q, step_d;
   logic      held_q, held_d;
   logic      fault_q, fault_d;
   logic      lost_part;
   logic      part_held;
   logic      part_gone;

   assign part_held = !sense.open && !sense.closed;
   assign part_gone = sense.open && !sense.closed;
   assign lost_part = step_carries(step_q) && sense.closed;

   always_comb begin
      step_d = step_q;
      held_d = held_q;
      fault_d = fault_q;
      if (lost_part) begin
         step_d  = ST_ABORT_UP;
         held_d  = 1'b0;
         fault_d = 1'b1;
      end else begin
         unique case (step_q)
            ST_PARK: begin
               if (fault_clr) fault_d = 1'b0;
               if (start_req && !fault_q) step_d = ST_BACK;
            end
            ST_BACK:      if (sense.rear)   step_d = ST_LOWER_R;
            ST_LOWER_R:   if (sense.bottom) step_d = ST_GRIP;
            ST_GRIP: begin
               if (part_held) begin
                  step_d = ST_LIFT_R;
                  held_d = 1'b1;
               end
            end
            ST_LIFT_R:    if (sense.top)    step_d = ST_FWD;
            ST_FWD:       if (sense.front)  step_d = ST_LOWER_F;
            ST_LOWER_F:   if (sense.bottom) step_d = ST_RELEASE;
            ST_RELEASE: begin
               if (part_gone) begin
                  step_d = ST_LIFT_F;
                  held_d = 1'b0;
               end
            end
            ST_LIFT_F:    if (sense.top)    step_d = ST_PARK;
            ST_ABORT_UP:  if (sense.top)    step_d = ST_ABORT_FWD;
            ST_ABORT_FWD: if (sense.front)  step_d = ST_PARK;
            default:      step_d = ST_PARK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= ST_PARK;
         held_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         step_q  <= step_d;
         held_q  <= held_d;
         fault_q <= fault_d;
      end
   end

   assign step  = step_q;
   assign held  = held_q;
   assign fault = fault_q;

endmodule

// File: rtl/arm_seq_drive.sv
module arm_seq_drive
   import arm_seq_pkg::*;
(
   input  arm_step_e step,
   input  logic      bottom_raw,
   input  logic      bottom_sync,
   output arm_cmd_t  cmd
);

   arm_cmd_t base;
   logic     low_zone;

   assign base     = step_to_cmd(step);
   assign low_zone = bottom_raw || bottom_sync;

   always_comb begin
      cmd = base;
      if (low_zone) begin
         cmd.back = 1'b0;
         cmd.fwd  = 1'b0;
      end
   end

endmodule

// File: rtl/arm_seq.sv
module arm_seq
   import arm_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_req,
   input  logic                  fault_clr,
   input  logic                  sens_rear,
   input  logic                  sens_front,
   input  logic                  sens_bottom,
   input  logic                  sens_top,
   input  logic                  grip_open,
   input  logic                  grip_closed,
   output logic                  cmd_back,
   output logic                  cmd_fwd,
   output logic                  cmd_down,
   output logic                  cmd_up,
   output logic                  cmd_grip,
   output logic [ARM_STEP_W-1:0] step_o,
   output logic                  held_o,
   output logic                  fault_o
);

   localparam int MAX_SYNC = 4;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("arm_seq: SYNC_STAGES out of range");
      end
   endgenerate

   arm_sense_t raw_sense;
   arm_sense_t sync_sense;
   logic [ARM_SENSE_W-1:0] sync_bits;
   arm_step_e  step;
   arm_cmd_t   cmd;

   assign raw_sense = '{rear: sens_rear, front: sens_front, bottom: sens_bottom,
                        top: sens_top, open: grip_open, closed: grip_closed};

   arm_seq_sync #(.W(ARM_SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_sense),
      .q     (sync_bits)
   );
   assign sync_sense = sync_bits;

   arm_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .fault_clr (fault_clr),
      .sense     (sync_sense),
      .step      (step),
      .held      (held_o),
      .fault     (fault_o)
   );

   arm_seq_drive u_drive (
      .step        (step),
      .bottom_raw  (sens_bottom),
      .bottom_sync (sync_sense.bottom),
      .cmd         (cmd)
   );

   assign cmd_back = cmd.back;
   assign cmd_fwd  = cmd.fwd;
   assign cmd_down = cmd.down;
   assign cmd_up   = cmd.up;
   assign cmd_grip = cmd.grip;
   assign step_o   = step;

endmodule

// File: rtl/arm_seq_chk.sv
module arm_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_req,
   input logic       sens_bottom,
   input logic       cmd_back,
   input logic       cmd_fwd,
   input logic       cmd_down,
   input logic       cmd_up,
   input logic [3:0] step_o,
   input logic       held_o,
   input logic       fault_o
);

   assert_motion_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_back, cmd_fwd, cmd_down, cmd_up}));

   assert_bottom_interlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sens_bottom |-> (!cmd_fwd && !cmd_back));

   assert_abort_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> (step_o == 4'd9));

   assert_no_place_after_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (step_o != 4'd6 && step_o != 4'd7));

   assert_held_fault_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(held_o && fault_o));

   assert_fault_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && step_o != 4'd0) |=> fault_o);

   assert_park_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o == 4'd0 && (!start_req || fault_o)) |=> (step_o == 4'd0));

endmodule

bind arm_seq arm_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_req   (start_req),
   .sens_bottom (sens_bottom),
   .cmd_back    (cmd_back),
   .cmd_fwd     (cmd_fwd),
   .cmd_down    (cmd_down),
   .cmd_up      (cmd_up),
   .step_o      (step_o),
   .held_o      (held_o),
   .fault_o     (fault_o)
);

// File: tb/arm_seq_test.sv
module arm_seq_test;

   localparam int HMAX = 6;
   localparam int VMAX = 8;
   localparam int GDLY = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic fault_clr = 1'b0;
   logic cmd_back, cmd_fwd, cmd_down, cmd_up, cmd_grip;
   logic [3:0] step_o;
   logic held_o, fault_o;

   int hpos = HMAX;
   int vpos = VMAX;
   int gstate = 0;
   int gcnt = 0;
   int placed = 0;
   int fb_after_fault = 0;
   int interlock_bad = 0;
   int onehot_bad = 0;
   logic freeze = 1'b0;
   logic drop_req = 1'b0;
   logic part_ready = 1'b1;

   logic sens_rear, sens_front, sens_bottom, sens_top, grip_open, grip_closed;
   assign sens_rear   = (hpos == 0);
   assign sens_front  = (hpos == HMAX);
   assign sens_bottom = (vpos == 0);
   assign sens_top    = (vpos == VMAX);
   assign grip_open   = (gstate == 0);
   assign grip_closed = (gstate == 2);

   int checks = 0;
   int fails = 0;
   logic [3:0] expq[$];
   logic [3:0] last_step = 4'd0;
   logic mon_on = 1'b0;

   always #4 clk = ~clk;

   arm_seq #(.SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .fault_clr(fault_clr),
      .sens_rear(sens_rear), .sens_front(sens_front), .sens_bottom(sens_bottom),
      .sens_top(sens_top), .grip_open(grip_open), .grip_closed(grip_closed),
      .cmd_back(cmd_back), .cmd_fwd(cmd_fwd), .cmd_down(cmd_down), .cmd_up(cmd_up),
      .cmd_grip(cmd_grip), .step_o(step_o), .held_o(held_o), .fault_o(fault_o)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // plant model, updated away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if ((cmd_fwd || cmd_back) && vpos == 0) interlock_bad++;
         if ((int'(cmd_back) + int'(cmd_fwd) + int'(cmd_down) + int'(cmd_up)) > 1) onehot_bad++;
         if (fault_o && hpos == HMAX && vpos == 0) fb_after_fault++;
      end
      if (!freeze) begin
         if (cmd_back && hpos > 0) hpos--;
         if (cmd_fwd && hpos < HMAX) hpos++;
         if (cmd_down && vpos > 0) vpos--;
         if (cmd_up && vpos < VMAX) vpos++;
         if (gstate == 1 && drop_req) begin
            gstate = 2;
            gcnt = 0;
         end else if (cmd_grip && gstate == 0) begin
            gcnt++;
            if (gcnt >= GDLY) begin
               gstate = (part_ready && hpos == 0 && vpos == 0) ? 1 : 2;
               gcnt = 0;
            end
         end else if (!cmd_grip && gstate != 0) begin
            gcnt++;
            if (gcnt >= GDLY) begin
               if (gstate == 1 && hpos == HMAX && vpos == 0) placed++;
               gstate = 0;
               gcnt = 0;
            end
         end else begin
            gcnt = 0;
         end
      end
   end

   // scoreboard monitor: every step change must match the next expected code
   always @(negedge clk) begin
      if (mon_on && step_o !== last_step) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2 unexpected step change", int'(step_o), int'(last_step));
         end else begin
            logic [3:0] e;
            e = expq.pop_front();
            check(step_o === e, "R2 step order", int'(step_o), int'(e));
         end
         last_step = step_o;
      end
   end

   function automatic logic [4:0] exp_cmd(input logic [3:0] s);
      case (s)
         4'd1:  return 5'b10000;
         4'd2:  return 5'b00100;
         4'd3:  return 5'b00001;
         4'd4:  return 5'b00011;
         4'd5:  return 5'b01001;
         4'd6:  return 5'b00101;
         4'd8:  return 5'b00010;
         4'd9:  return 5'b00010;
         4'd10: return 5'b01000;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic push(input int n, input logic [3:0] s [16]);
      for (int i = 0; i < n; i++) expq.push_back(s[i]);
   endtask

   task automatic wait_step(input logic [3:0] s, input int lim, input string req);
      int n;
      n = 0;
      while (step_o !== s && n < lim) begin
         @(negedge clk);
         n++;
      end
      check(step_o === s, req, int'(step_o), int'(s));
      check({cmd_back, cmd_fwd, cmd_down, cmd_up, cmd_grip} === exp_cmd(s), "R3 commands",
            int'({cmd_back, cmd_fwd, cmd_down, cmd_up, cmd_grip}), int'(exp_cmd(s)));
   endtask

   task automatic pulse_start();
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic pulse_clr();
      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
   endtask

   task automatic full_cycle();
      logic [3:0] seq [16];
      int p0;
      seq = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd0,
              4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
      push(9, seq);
      p0 = placed;
      pulse_start();
      for (int k = 1; k <= 8; k++) wait_step(4'(k), 200, "R2 normal cycle");
      wait_step(4'd0, 200, "R2 return to park");
      repeat (GDLY + 2) @(negedge clk);
      check(placed == p0 + 1, "R2 part placed", placed, p0 + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [3:0] seq [16];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(step_o === 4'd0, "R1 step after reset", int'(step_o), 0);
      check({cmd_back, cmd_fwd, cmd_down, cmd_up, cmd_grip} === 5'b0, "R1 commands idle",
            int'({cmd_back, cmd_fwd, cmd_down, cmd_up, cmd_grip}), 0);
      check(fault_o === 1'b0 && held_o === 1'b0, "R1 flags clear",
            int'({fault_o, held_o}), 0);
      mon_on = 1'b1;

      // R10 park wait without start
      repeat (20) @(negedge clk);
      check(step_o === 4'd0, "R10 park without start", int'(step_o), 0);

      // R2/R3/R8 normal cycle
      full_cycle();

      // R2 stall: step 5 holds while the plant is frozen
      seq = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd0,
              4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
      push(9, seq);
      pulse_start();
      wait_step(4'd5, 300, "R2 reach forward");
      check(held_o === 1'b1, "R8 held during transport", int'(held_o), 1);
      freeze = 1'b1;
      repeat (40) @(negedge clk);
      check(step_o === 4'd5 && cmd_fwd === 1'b1, "R2 waits for front switch",
            int'(step_o), 5);
      freeze = 1'b0;
      wait_step(4'd0, 300, "R2 finish after stall");
      check(held_o === 1'b0, "R8 held cleared after release", int'(held_o), 0);

      // R6 drop during forward travel
      begin
         int p0;
         p0 = placed;
         seq = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd10, 4'd0,
                 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
         push(8, seq);
         pulse_start();
         wait_step(4'd5, 300, "R6 reach forward");
         @(negedge clk);
         drop_req = 1'b1;
         wait_step(4'd9, 50, "R6 abort lift");
         drop_req = 1'b0;
         check(fault_o === 1'b1 && held_o === 1'b0, "R6 fault set held dropped",
               int'({fault_o, held_o}), 2);
         wait_step(4'd0, 300, "R6 parked after drop");
         repeat (GDLY + 2) @(negedge clk);
         check(placed == p0, "R6 no placement", placed, p0);
      end

      // R9 start ignored while fault latched
      pulse_start();
      repeat (20) @(negedge clk);
      check(step_o === 4'd0 && fault_o === 1'b1, "R9 start ignored with fault",
            int'(step_o), 0);
      pulse_clr();
      check(fault_o === 1'b0, "R9 clear at park", int'(fault_o), 0);

      // R6 drop during lift, with clear attempt mid-abort (R9)
      seq = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd9, 4'd10, 4'd0, 4'd0,
              4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
      push(7, seq);
      pulse_start();
      wait_step(4'd4, 300, "R6 reach lift");
      drop_req = 1'b1;
      wait_step(4'd9, 50, "R6 abort from lift");
      drop_req = 1'b0;
      wait_step(4'd10, 100, "R6 abort forward");
      pulse_clr();
      check(fault_o === 1'b1, "R9 clear ignored away from park", int'(fault_o), 1);
      wait_step(4'd0, 300, "R6 parked after lift drop");
      check(fault_o === 1'b1, "R9 fault still latched at park", int'(fault_o), 1);
      pulse_clr();
      check(fault_o === 1'b0, "R9 second clear at park", int'(fault_o), 0);

      // R7 grip closes on nothing
      repeat (GDLY + 2) @(negedge clk);
      part_ready = 1'b0;
      seq = '{4'd1, 4'd2, 4'd3, 4'd9, 4'd10, 4'd0, 4'd0, 4'd0,
              4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
      push(6, seq);
      pulse_start();
      wait_step(4'd9, 300, "R7 abort on empty grip");
      check(fault_o === 1'b1, "R7 fault on empty grip", int'(fault_o), 1);
      wait_step(4'd0, 300, "R7 parked");
      part_ready = 1'b1;
      pulse_clr();
      repeat (GDLY + 2) @(negedge clk);

      // R6 drop while lowering at front
      seq = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10,
              4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0};
      push(9, seq);
      pulse_start();
      wait_step(4'd6, 300, "R6 reach lower front");
      drop_req = 1'b1;
      wait_step(4'd9, 50, "R6 abort from lower front");
      drop_req = 1'b0;
      wait_step(4'd0, 300, "R6 parked after front drop");
      check(fb_after_fault == 0, "R6 front-bottom not reached", fb_after_fault, 0);
      pulse_clr();
      repeat (GDLY + 2) @(negedge clk);

      // recovery cycle
      full_cycle();

      check(interlock_bad == 0, "R5 horizontal command at bottom", interlock_bad, 0);
      check(onehot_bad == 0, "R4 single motion command", onehot_bad, 0);
      check(expq.size() == 0, "R2 all expected steps seen", expq.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule